// File: doc/BRIEF.md
# SDRAM Auto-Precharge Bank Tracker

This block follows the registered command stream of a multi-bank SDRAM clock by clock and keeps a state for every bank. The states are idle, page open, write burst, write recovery, precharging and read burst. A memory controller or a protocol monitor uses it to know when each bank is busy, which write beats the device takes, and in which cycle read data comes back.

Write and read bursts share one data bus. A column command (read or write) to a second open bank therefore cuts off whatever burst is running. When the cut-off burst was a write with auto precharge, the write-recovery count for that bank starts on the edge that registers the interrupting command. The bank then precharges and returns to idle. The timings are parameters counted in clocks: recovery, precharge, CAS latency and burst length.

Top module: `sdram_ap_tracker`

## Requirements
- R1: While reset is held and afterwards, until a command arrives, every bank reports idle (state code 0) with its ready flag high, and `wr_acc`, `rd_valid` and `proto_err` are low. Each bank's 3-bit state sits at `bank_state[3i+2:3i]`. The codes are idle=0, open=1, write burst=2, write recovery=3, precharging=4 and read burst=5.
- R2: An activate (`cmd_op`=1) to an idle bank makes it open in the next cycle and drops its ready flag. No-operation cycles (`cmd_op`=0) leave an open bank open.
- R3: A write (`cmd_op`=3) to an open bank opens a slot on the command edge and on each of the following BURST_LEN-1 edges. The column of each slot steps upward and wraps inside the aligned block of BURST_LEN columns. A slot whose `wr_beat` is high shows up one cycle later on `wr_acc` with its bank and column. A slot whose `wr_beat` is low is not accepted.
- R4: A write with auto precharge that nothing interrupts stays in the write burst until its last slot. It then spends T_WR cycles in write recovery and T_RP cycles precharging, and after that it is idle with its ready flag high.
- R5: A read (`cmd_op`=2) or a write to another open bank, registered while a bank is in a write burst, ends that burst on the same edge. The write-recovery count of the interrupted bank starts on that edge. At most one bank is ever in a burst.
- R6: The last beat accepted for an interrupted write is the one presented one edge before the interrupting command. The beat on the interrupting edge belongs to the new write, or to nobody when the new command is a read.
- R7: The read data beat j of a read registered at edge E is flagged on `rd_valid` with its bank and column in the cycle that ends at edge E+j+CAS_LAT.
- R8: An interrupting write with auto precharge runs its full burst and then goes through its own recovery and precharge. A write without auto precharge returns to open after its burst.
- R9: A read burst ends after BURST_LEN slots or when a column command goes to another bank. With auto precharge it then precharges for T_RP cycles and becomes idle; without it, the bank returns to open.
- R10: An activate to a bank that is not idle, or a read or write to a bank that is not open, is dropped. It changes no bank state and produces no data slot, and it raises `proto_err` for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | Registered command: 0 nop, 1 activate, 2 read, 3 write |
| cmd_bank | input | BANK_W | Target bank of the command |
| cmd_col | input | COL_W | Starting column of a read or write |
| cmd_ap | input | 1 | Auto precharge requested with a read or write |
| wr_beat | input | 1 | Write data present on this edge |
| bank_state | output | 3*NUM_BANKS | Per-bank state codes |
| bank_ready | output | NUM_BANKS | Bank is idle and free |
| wr_acc | output | 1 | A write beat was accepted on the previous edge |
| wr_acc_bank | output | BANK_W | Bank of the accepted beat |
| wr_acc_col | output | COL_W | Column of the accepted beat |
| rd_valid | output | 1 | Read data beat is on the bus |
| rd_bank | output | BANK_W | Bank of the read beat |
| rd_col | output | COL_W | Column of the read beat |
| proto_err | output | 1 | Previous command was illegal and dropped |

## Verification
Bank states and `wr_acc` are registered, so each is due in the cycle after the edge that registers its command. Read beats are due CAS_LAT-1 cycles after that, counted from the edge of each slot. The bench drives every command at a falling edge, moves through exactly one rising edge per step, and samples at the next falling edge. It numbers the steps from the interrupted burst's command edge and works out each due cycle from that step number with the timing parameters. The sweep covers read and write auto-precharge bursts, interrupted by reads and writes with and without auto precharge at each possible beat offset, and also left uninterrupted.

// File: rtl/apt_pkg.sv
package apt_pkg;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_ACT = 2'd1,
        OP_RD  = 2'd2,
        OP_WR  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        BS_IDLE   = 3'd0,
        BS_OPEN   = 3'd1,
        BS_WBURST = 3'd2,
        BS_WBACK  = 3'd3,
        BS_PRECH  = 3'd4,
        BS_RBURST = 3'd5
    } bank_st_e;

    // Per-bank decoded control, broadcast from the top each cycle
    typedef struct packed {
        logic act_go;     // legal activate to this bank
        logic col_mine;   // legal read/write to this bank
        logic col_other;  // legal read/write to some other bank
        logic is_wr;      // column command is a write
        logic ap;         // auto precharge requested
    } bank_ctl_t;

    function automatic logic is_burst(input bank_st_e s);
        return (s == BS_WBURST) || (s == BS_RBURST);
    endfunction

endpackage

// File: rtl/apt_bank_fsm.sv
module apt_bank_fsm
    import apt_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int T_WR      = 2,
    parameter int T_RP      = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  bank_ctl_t ctl,
    output bank_st_e  st
);
    localparam int TMAX = (BURST_LEN > T_WR) ? ((BURST_LEN > T_RP) ? BURST_LEN : T_RP)
                                             : ((T_WR > T_RP) ? T_WR : T_RP);
    localparam int TW = $clog2(TMAX + 1);

    logic [TW-1:0] tmr;
    logic          ap_q;
    logic          last_tick;

    assign last_tick = (tmr <= TW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= BS_IDLE;
            tmr  <= '0;
            ap_q <= 1'b0;
        end else begin
            case (st)
                BS_IDLE: begin
                    if (ctl.act_go) st <= BS_OPEN;
                end
                BS_OPEN: begin
                    if (ctl.col_mine) begin
                        st   <= ctl.is_wr ? BS_WBURST : BS_RBURST;
                        tmr  <= TW'(BURST_LEN - 1);
                        ap_q <= ctl.ap;
                    end
                end
                BS_WBURST, BS_RBURST: begin
                    if (ctl.col_other || last_tick) begin
                        if (!ap_q) begin
                            st <= BS_OPEN;
                        end else if (st == BS_WBURST) begin
                            st  <= BS_WBACK;
                            tmr <= TW'(T_WR);
                        end else begin
                            st  <= BS_PRECH;
                            tmr <= TW'(T_RP);
                        end
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                BS_WBACK: begin
                    if (last_tick) begin
                        st  <= BS_PRECH;
                        tmr <= TW'(T_RP);
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                BS_PRECH: begin
                    if (last_tick) st <= BS_IDLE;
                    else           tmr <= tmr - 1'b1;
                end
                default: st <= BS_IDLE;
            endcase
        end
    end

    // R4
    wback_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (st == BS_WBACK && $past(st) != BS_WBACK) |-> $past(st) == BS_WBURST);

    // R9
    prech_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (st == BS_PRECH && $past(st) != BS_PRECH) |->
        ($past(st) == BS_WBACK || $past(st) == BS_RBURST));

    // R2
    open_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == BS_IDLE && st != BS_IDLE) |-> st == BS_OPEN);

    // R4
    idle_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(st) != BS_IDLE && st == BS_IDLE) |-> $past(st) == BS_PRECH);

endmodule

// File: rtl/apt_beat_gen.sv
module apt_beat_gen #(
    parameter int BANK_W    = 2,
    parameter int COL_W     = 8,
    parameter int BURST_LEN = 4,
    parameter bit FOR_WRITE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              col_go,
    input  logic              is_wr,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    output logic              slot_v,
    output logic [BANK_W-1:0] slot_bank,
    output logic [COL_W-1:0]  slot_col
);
    localparam int LGB = $clog2(BURST_LEN);
    localparam int RW  = (LGB < 1) ? 1 : LGB;

    logic [RW-1:0]     rem;
    logic [BANK_W-1:0] cur_bank;
    logic [COL_W-1:0]  cur_col;
    logic              mine, other;

    function automatic logic [COL_W-1:0] step_col(input logic [COL_W-1:0] c);
        logic [COL_W-1:0] r;
        r = c;
        r[LGB-1:0] = c[LGB-1:0] + 1'b1;
        return r;
    endfunction

    assign mine  = col_go && (is_wr == FOR_WRITE);
    assign other = col_go && (is_wr != FOR_WRITE);

    always_comb begin
        slot_v    = 1'b0;
        slot_bank = cur_bank;
        slot_col  = cur_col;
        if (mine) begin
            slot_v    = 1'b1;
            slot_bank = cmd_bank;
            slot_col  = cmd_col;
        end else if (!other && rem != '0) begin
            slot_v = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem      <= '0;
            cur_bank <= '0;
            cur_col  <= '0;
        end else if (mine) begin
            rem      <= RW'(BURST_LEN - 1);
            cur_bank <= cmd_bank;
            cur_col  <= step_col(cmd_col);
        end else if (other) begin
            rem <= '0;
        end else if (rem != '0) begin
            rem     <= rem - 1'b1;
            cur_col <= step_col(cur_col);
        end
    end

endmodule

// File: rtl/apt_rd_delay.sv
module apt_rd_delay #(
    parameter int BANK_W  = 2,
    parameter int COL_W   = 8,
    parameter int CAS_LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_v,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [COL_W-1:0]  in_col,
    output logic              out_v,
    output logic [BANK_W-1:0] out_bank,
    output logic [COL_W-1:0]  out_col
);
    logic [CAS_LAT-1:0] v_q;
    logic [BANK_W-1:0]  b_q [CAS_LAT];
    logic [COL_W-1:0]   c_q [CAS_LAT];

    always_ff @(posedge clk) begin
        if (rst) v_q[0] <= 1'b0;
        else     v_q[0] <= in_v;
        b_q[0] <= in_bank;
        c_q[0] <= in_col;
    end

    for (genvar i = 1; i < CAS_LAT; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) v_q[i] <= 1'b0;
            else     v_q[i] <= v_q[i-1];
            b_q[i] <= b_q[i-1];
            c_q[i] <= c_q[i-1];
        end
    end

    assign out_v    = v_q[CAS_LAT-1];
    assign out_bank = b_q[CAS_LAT-1];
    assign out_col  = c_q[CAS_LAT-1];

endmodule

// File: rtl/sdram_ap_tracker.sv
module sdram_ap_tracker
    import apt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int COL_W     = 8,
    parameter int BURST_LEN = 4,
    parameter int T_WR      = 2,
    parameter int T_RP      = 3,
    parameter int CAS_LAT   = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             cmd_op,
    input  logic [BANK_W-1:0]      cmd_bank,
    input  logic [COL_W-1:0]       cmd_col,
    input  logic                   cmd_ap,
    input  logic                   wr_beat,
    output logic [3*NUM_BANKS-1:0] bank_state,
    output logic [NUM_BANKS-1:0]   bank_ready,
    output logic                   wr_acc,
    output logic [BANK_W-1:0]      wr_acc_bank,
    output logic [COL_W-1:0]       wr_acc_col,
    output logic                   rd_valid,
    output logic [BANK_W-1:0]      rd_bank,
    output logic [COL_W-1:0]       rd_col,
    output logic                   proto_err
);
    op_e                  op;
    bank_st_e             st_arr [NUM_BANKS];
    bank_st_e             tgt_st;
    logic                 in_range, is_col, act_ok, col_go, err_d;
    logic [NUM_BANKS-1:0] burst_vec;

    assign op       = op_e'(cmd_op);
    assign in_range = {1'b0, cmd_bank} < (BANK_W + 1)'(NUM_BANKS);
    assign is_col   = (op == OP_RD) || (op == OP_WR);

    always_comb begin
        tgt_st = BS_IDLE;
        for (int i = 0; i < NUM_BANKS; i++)
            if (cmd_bank == BANK_W'(i)) tgt_st = st_arr[i];
    end

    assign act_ok = (op == OP_ACT) && in_range && (tgt_st == BS_IDLE);
    assign col_go = is_col && in_range && (tgt_st == BS_OPEN);
    assign err_d  = ((op == OP_ACT) && !act_ok) || (is_col && !col_go);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_ctl_t ctl;
        logic      sel;
        assign sel           = (cmd_bank == BANK_W'(b));
        assign ctl.act_go    = act_ok && sel;
        assign ctl.col_mine  = col_go && sel;
        assign ctl.col_other = col_go && !sel;
        assign ctl.is_wr     = (op == OP_WR);
        assign ctl.ap        = cmd_ap;

        apt_bank_fsm #(
            .BURST_LEN(BURST_LEN), .T_WR(T_WR), .T_RP(T_RP)
        ) u_fsm (
            .clk(clk), .rst(rst), .ctl(ctl), .st(st_arr[b])
        );

        assign bank_state[3*b +: 3] = st_arr[b];
        assign bank_ready[b]        = (st_arr[b] == BS_IDLE);
        assign burst_vec[b]         = is_burst(st_arr[b]);
    end

    // Write slot generator and registered acceptance
    logic              ws_v;
    logic [BANK_W-1:0] ws_bank;
    logic [COL_W-1:0]  ws_col;

    apt_beat_gen #(
        .BANK_W(BANK_W), .COL_W(COL_W), .BURST_LEN(BURST_LEN), .FOR_WRITE(1'b1)
    ) u_wgen (
        .clk(clk), .rst(rst), .col_go(col_go), .is_wr(op == OP_WR),
        .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .slot_v(ws_v), .slot_bank(ws_bank), .slot_col(ws_col)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_acc      <= 1'b0;
            wr_acc_bank <= '0;
            wr_acc_col  <= '0;
            proto_err   <= 1'b0;
        end else begin
            wr_acc      <= ws_v && wr_beat;
            wr_acc_bank <= ws_bank;
            wr_acc_col  <= ws_col;
            proto_err   <= err_d;
        end
    end

    // Read slot generator followed by the CAS latency line
    logic              rs_v;
    logic [BANK_W-1:0] rs_bank;
    logic [COL_W-1:0]  rs_col;

    apt_beat_gen #(
        .BANK_W(BANK_W), .COL_W(COL_W), .BURST_LEN(BURST_LEN), .FOR_WRITE(1'b0)
    ) u_rgen (
        .clk(clk), .rst(rst), .col_go(col_go), .is_wr(op == OP_WR),
        .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .slot_v(rs_v), .slot_bank(rs_bank), .slot_col(rs_col)
    );

    apt_rd_delay #(
        .BANK_W(BANK_W), .COL_W(COL_W), .CAS_LAT(CAS_LAT)
    ) u_rdly (
        .clk(clk), .rst(rst),
        .in_v(rs_v), .in_bank(rs_bank), .in_col(rs_col),
        .out_v(rd_valid), .out_bank(rd_bank), .out_col(rd_col)
    );

    // R5
    single_burst_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(burst_vec) <= 1);

    // R10
    err_src_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> $past(cmd_op) != 2'd0);

    // R3
    wr_acc_beat_chk: assert property (@(posedge clk) disable iff (rst)
        wr_acc |-> $past(wr_beat));

endmodule

// File: tb/sdram_ap_tracker_tb.sv
module sdram_ap_tracker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB  = 4;
    localparam int BL  = 4;
    localparam int TWR = 2;
    localparam int TRP = 3;
    localparam int CL  = 3;
    localparam logic [1:0] NOP = 2'd0, ACT = 2'd1, RD = 2'd2, WR = 2'd3;
    localparam logic [7:0] COL_A = 8'h0E, COL_D = 8'h21;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       cmd_op = NOP;
    logic [1:0]       cmd_bank = '0;
    logic [7:0]       cmd_col = '0;
    logic             cmd_ap = 1'b0;
    logic             wr_beat = 1'b0;
    logic [3*NB-1:0]  bank_state;
    logic [NB-1:0]    bank_ready;
    logic             wr_acc, rd_valid, proto_err;
    logic [1:0]       wr_acc_bank, rd_bank;
    logic [7:0]       wr_acc_col, rd_col;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_ap_tracker #(
        .NUM_BANKS(NB), .COL_W(8), .BURST_LEN(BL), .T_WR(TWR), .T_RP(TRP), .CAS_LAT(CL)
    ) u_dut (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .cmd_ap(cmd_ap), .wr_beat(wr_beat), .bank_state(bank_state), .bank_ready(bank_ready),
        .wr_acc(wr_acc), .wr_acc_bank(wr_acc_bank), .wr_acc_col(wr_acc_col),
        .rd_valid(rd_valid), .rd_bank(rd_bank), .rd_col(rd_col), .proto_err(proto_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] op, input int bk, input logic [7:0] col,
                        input logic ap, input logic beat);
        cmd_op = op; cmd_bank = bk[1:0]; cmd_col = col; cmd_ap = ap; wr_beat = beat;
        @(posedge clk);
        @(negedge clk);
        cmd_op = NOP; wr_beat = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(NOP, 0, 8'h0, 1'b0, 1'b0);
        step(NOP, 0, 8'h0, 1'b0, 1'b0);
        rst = 1'b0;
    endtask

    function automatic int st_of(input int b);
        return int'(bank_state[3*b +: 3]);
    endfunction

    function automatic logic [7:0] wrap(input logic [7:0] c, input int j);
        logic [1:0] lo;
        lo = c[1:0] + 2'(j);
        return {c[7:2], lo};
    endfunction

    // Expected state of the first (interrupted) bank after step t
    function automatic int exp_b0(input int t, input logic [1:0] op0, input int k);
        int x;
        x = (k > 0) ? k : BL - 1;
        if (t < x) return (op0 == WR) ? 2 : 5;
        if (op0 == WR) begin
            if (t < x + TWR) return 3;
            if (t < x + TWR + TRP) return 4;
            return 0;
        end
        if (t < x + TRP) return 4;
        return 0;
    endfunction

    // Expected state of the interrupting bank after step t
    function automatic int exp_b1(input int t, input logic [1:0] op1, input logic ap1, input int k);
        int e;
        if (k == 0 || t < k) return 1;
        e = k + BL - 1;
        if (t < e) return (op1 == WR) ? 2 : 5;
        if (!ap1) return 1;
        if (op1 == WR) begin
            if (t < e + TWR) return 3;
            if (t < e + TWR + TRP) return 4;
            return 0;
        end
        if (t < e + TRP) return 4;
        return 0;
    endfunction

    task automatic run_case(input logic [1:0] op0, input logic [1:0] op1,
                            input logic ap1, input int k);
        int beat_end, j0;
        bit ew, er;
        int eb, ec;
        string tag;
        beat_end = (k > 0) ? k : BL;
        do_reset();
        step(ACT, 0, 8'h0, 1'b0, 1'b0);
        step(ACT, 1, 8'h0, 1'b0, 1'b0);
        for (int t = 0; t <= 20; t++) begin
            if (t == 0)      step(op0, 0, COL_A, 1'b1, 1'b1);
            else if (t == k) step(op1, 1, COL_D, ap1, 1'b1);
            else             step(NOP, 0, 8'h0, 1'b0, 1'b1);
            tag = (k > 0) ? "R5" : ((op0 == WR) ? "R4" : "R9");
            chk(st_of(0) == exp_b0(t, op0, k), tag, st_of(0), exp_b0(t, op0, k));
            chk(bank_ready[0] == (exp_b0(t, op0, k) == 0), "R4", bank_ready[0],
                exp_b0(t, op0, k) == 0);
            tag = (op1 == WR) ? "R8" : "R9";
            chk(st_of(1) == exp_b1(t, op1, ap1, k), tag, st_of(1), exp_b1(t, op1, ap1, k));
            chk(st_of(2) == 0 && st_of(3) == 0, "R1", {st_of(3), st_of(2)}, 0);
            // write acceptance
            ew = 1'b0; eb = 0; ec = 0;
            if (op0 == WR && t < beat_end) begin
                ew = 1'b1; eb = 0; ec = int'(wrap(COL_A, t));
            end else if (k > 0 && op1 == WR && t >= k && t < k + BL) begin
                ew = 1'b1; eb = 1; ec = int'(wrap(COL_D, t - k));
            end
            chk(wr_acc == ew, "R6", wr_acc, ew);
            if (ew) chk(wr_acc_bank == eb[1:0] && wr_acc_col == ec[7:0], "R3",
                        {wr_acc_bank, wr_acc_col}, {eb[1:0], ec[7:0]});
            // read data
            er = 1'b0; eb = 0; ec = 0; j0 = t - (CL - 1);
            if (op0 == RD && j0 >= 0 && j0 < beat_end) begin
                er = 1'b1; eb = 0; ec = int'(wrap(COL_A, j0));
            end else if (k > 0 && op1 == RD && j0 >= k && j0 < k + BL) begin
                er = 1'b1; eb = 1; ec = int'(wrap(COL_D, j0 - k));
            end
            chk(rd_valid == er, "R7", rd_valid, er);
            if (er) chk(rd_bank == eb[1:0] && rd_col == ec[7:0], "R7",
                        {rd_bank, rd_col}, {eb[1:0], ec[7:0]});
            chk(proto_err == 1'b0, "R10", proto_err, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk(bank_state == '0, "R1", int'(bank_state), 0);
        chk(bank_ready == '1, "R1", int'(bank_ready), 4'hF);
        chk(!wr_acc && !rd_valid && !proto_err, "R1", {wr_acc, rd_valid, proto_err}, 0);

        // R2: activate and hold through NOPs
        step(ACT, 2, 8'h0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            chk(st_of(2) == 1, "R2", st_of(2), 1);
            chk(bank_ready[2] == 1'b0, "R2", bank_ready[2], 0);
            step(NOP, 0, 8'h0, 1'b0, 1'b0);
        end

        // R10: activate to an open bank
        step(ACT, 2, 8'h0, 1'b0, 1'b0);
        chk(proto_err == 1'b1, "R10", proto_err, 1);
        chk(st_of(2) == 1, "R10", st_of(2), 1);
        step(NOP, 0, 8'h0, 1'b0, 1'b0);
        chk(proto_err == 1'b0, "R10", proto_err, 0);

        // R10: read to an idle bank is dropped
        step(RD, 3, 8'h10, 1'b1, 1'b0);
        chk(proto_err == 1'b1, "R10", proto_err, 1);
        for (int i = 0; i < CL + BL; i++) begin
            chk(st_of(3) == 0 && rd_valid == 1'b0, "R10", {st_of(3), rd_valid}, 0);
            step(NOP, 0, 8'h0, 1'b0, 1'b0);
        end

        // R3/R8: write without auto precharge, beat 1 missing
        step(WR, 2, 8'h40, 1'b0, 1'b1);
        chk(wr_acc && wr_acc_col == 8'h40, "R3", {wr_acc, wr_acc_col}, {1'b1, 8'h40});
        step(NOP, 0, 8'h0, 1'b0, 1'b0);
        chk(wr_acc == 1'b0, "R3", wr_acc, 0);
        step(NOP, 0, 8'h0, 1'b0, 1'b1);
        chk(wr_acc && wr_acc_col == 8'h42, "R3", {wr_acc, wr_acc_col}, {1'b1, 8'h42});
        step(NOP, 0, 8'h0, 1'b0, 1'b1);
        chk(wr_acc && wr_acc_col == 8'h43 && wr_acc_bank == 2'd2, "R3",
            {wr_acc_bank, wr_acc_col}, {2'd2, 8'h43});
        chk(st_of(2) == 1, "R8", st_of(2), 1);
        step(NOP, 0, 8'h0, 1'b0, 1'b1);
        chk(wr_acc == 1'b0, "R3", wr_acc, 0);

        // Sweep: first burst type x interrupt type x auto precharge x offset
        for (int a = 0; a < 2; a++) begin
            logic [1:0] op0;
            op0 = (a == 0) ? WR : RD;
            run_case(op0, NOP, 1'b0, 0);
            for (int b = 0; b < 2; b++)
                for (int p = 0; p < 2; p++)
                    for (int k = 1; k < BL; k++)
                        run_case(op0, (b == 0) ? WR : RD, p[0], k);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule